// File: doc/BRIEF.md
# Encoded Bus Clock Prescaler Chain

This block turns a free-running system clock into three clock-enable streams for a bus hierarchy. A high-speed bus enable is derived from the system clock through a 4-bit division code. Two peripheral bus enables are each derived from that high-speed enable through their own 3-bit code. All outputs are single-cycle enable pulses in the system clock domain. They are not derived clock nets.

Software writes the codes through a small write port that selects one of the three fields. A written code waits as a pending value. It moves into its divider only when the divider's current period ends, so no period is ever cut short. Each divider reports the code it is actually running. Software can compare that read-back against what it wrote to learn when the new ratio has taken effect.

The high-speed code is not a plain exponent. A clear top bit bypasses the divider. With the top bit set, the lower three bits select 2, 4, 8 or 16, and then 64, 128, 256 or 512. A ratio of 32 cannot be selected.

Top module: `bus_presc_chain`

## Requirements
- R1: After reset all three active codes read back as zero, and all three enables are high in every cycle until a write changes a code.
- R2: When the high-speed active code has bit 3 clear, `hclk_en` is high in every cycle, whatever bits 2:0 hold.
- R3: High-speed codes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 give one `hclk_en` pulse every 2, 4, 8 and 16 system clock cycles.
- R4: High-speed codes 4'b1100, 4'b1101, 4'b1110 and 4'b1111 give one `hclk_en` pulse every 64, 128, 256 and 512 cycles.
- R5: When a peripheral active code has bit 2 clear, that peripheral enable equals `hclk_en` in every cycle.
- R6: Peripheral codes 3'b100, 3'b101, 3'b110 and 3'b111 give one peripheral pulse per 2, 4, 8 and 16 `hclk_en` pulses.
- R7: `wr_sel` 2'b00 writes `wr_data[3:0]` to the high-speed field, 2'b01 writes `wr_data[2:0]` to the first peripheral field, and 2'b10 writes `wr_data[2:0]` to the second. A write to one field leaves the other two unchanged.
- R8: A divider counts from zero after reset. A pending code is loaded only in the cycle that ends the current period, with the pulse of that cycle. The period already running finishes at its old length, and the next one uses the new ratio.
- R9: Each read-back output shows the active code of its divider. It changes in the cycle after the pulse that ends the old period, and not when the write occurs.
- R10: A peripheral enable is never high in a cycle where `hclk_en` is low.
- R11: A write with `wr_sel` 2'b11 changes no pending or active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the code fields |
| wr_sel | input | 2 | Field select: 00 high-speed, 01 first peripheral, 10 second peripheral, 11 none |
| wr_data | input | 4 | Code to write (peripheral fields use bits 2:0) |
| hclk_en | output | 1 | High-speed bus clock enable |
| pclk1_en | output | 1 | First peripheral bus clock enable |
| pclk2_en | output | 1 | Second peripheral bus clock enable |
| ahb_code_rb | output | 4 | High-speed code currently in effect |
| apb1_code_rb | output | 3 | First peripheral code currently in effect |
| apb2_code_rb | output | 3 | Second peripheral code currently in effect |

## Verification
The bench steps through every high-speed code. This includes both bypass codes and the jump from 16 to 64. A decoder that treats the code as a plain exponent would produce a 32-cycle spacing where 64 is expected. A new ratio is written just after a pulse, and the bench measures the spacing to the next two pulses. A design that loads the code at once would produce a short first gap. One that never loads it would leave the second gap at the old length. The bench also changes one peripheral field while the other runs, and issues a write with the unused select. Cross-talk between fields, or a stray load, shows up as a wrong read-back or a pulse spacing that does not match.

// File: rtl/bus_presc_pkg.sv
package bus_presc_pkg;

    localparam int AHB_CODE_W    = 4;
    localparam int APB_CODE_W    = 3;
    localparam int AHB_MAX_SHIFT = 9;
    localparam int APB_MAX_SHIFT = 4;
    localparam int SHIFT_W       = 4;
    localparam int APB_COUNT     = 2;

    typedef enum logic [1:0] {
        SEL_AHB  = 2'b00,
        SEL_APB1 = 2'b01,
        SEL_APB2 = 2'b10,
        SEL_NONE = 2'b11
    } wr_sel_e;

    typedef enum logic {
        MAP_AHB = 1'b0,
        MAP_APB = 1'b1
    } map_kind_e;

    typedef struct packed {
        logic [AHB_CODE_W-1:0] ahb;
        logic [APB_CODE_W-1:0] apb1;
        logic [APB_CODE_W-1:0] apb2;
    } code_set_t;

    // High-speed code to log2 of ratio; the ratio 32 is skipped
    function automatic logic [SHIFT_W-1:0] ahb_shift(input logic [AHB_CODE_W-1:0] c);
        if (!c[3])      return '0;
        else if (!c[2]) return SHIFT_W'(c[1:0]) + SHIFT_W'(1);
        else            return SHIFT_W'(c[1:0]) + SHIFT_W'(6);
    endfunction

    // Peripheral code to log2 of ratio
    function automatic logic [SHIFT_W-1:0] apb_shift(input logic [APB_CODE_W-1:0] c);
        if (!c[2]) return '0;
        else       return SHIFT_W'(c[1:0]) + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/presc_code_regs.sv
module presc_code_regs
    import bus_presc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [AHB_CODE_W-1:0] wr_data,
    output code_set_t             pend
);

    wr_sel_e sel;
    assign sel = wr_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_AHB:  pend.ahb  <= wr_data;
                SEL_APB1: pend.apb1 <= wr_data[APB_CODE_W-1:0];
                SEL_APB2: pend.apb2 <= wr_data[APB_CODE_W-1:0];
                default:  ;
            endcase
        end
    end

    // R11
    none_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NONE) |=> $stable(pend));

    // R7
    field_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_APB1) |=> ($stable(pend.ahb) && $stable(pend.apb2)));

endmodule

// File: rtl/presc_stage.sv
module presc_stage
    import bus_presc_pkg::*;
#(
    parameter int        CODE_W    = 4,
    parameter map_kind_e MAP       = MAP_AHB,
    parameter int        MAX_SHIFT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic [CODE_W-1:0] pend_code,
    output logic              tick_out,
    output logic [CODE_W-1:0] act_code
);

    localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [SHIFT_W-1:0] shift;
    logic [CNT_W:0]     span;
    logic [CNT_W-1:0]   limit;
    logic [CNT_W-1:0]   cnt;
    logic               at_end;

    generate
        if (MAP == MAP_AHB) begin : g_ahb_map
            assign shift = ahb_shift(AHB_CODE_W'(act_code));
        end else begin : g_apb_map
            assign shift = apb_shift(APB_CODE_W'(act_code));
        end
    endgenerate

    assign span     = (CNT_W+1)'(1) << shift;
    assign limit    = CNT_W'(span - (CNT_W+1)'(1));
    assign at_end   = (cnt == limit);
    assign tick_out = tick_in & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_code <= '0;
        end else if (tick_in) begin
            if (at_end) begin
                cnt      <= '0;
                act_code <= pend_code;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);

    // R8
    code_switch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_code) |-> $past(tick_out));

    // R10
    out_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> tick_in);

endmodule

// File: rtl/bus_presc_chain.sv
module bus_presc_chain
    import bus_presc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [AHB_CODE_W-1:0] wr_data,
    output logic                  hclk_en,
    output logic                  pclk1_en,
    output logic                  pclk2_en,
    output logic [AHB_CODE_W-1:0] ahb_code_rb,
    output logic [APB_CODE_W-1:0] apb1_code_rb,
    output logic [APB_CODE_W-1:0] apb2_code_rb
);

    code_set_t             pend;
    logic [APB_CODE_W-1:0] apb_pend [APB_COUNT];
    logic [APB_CODE_W-1:0] apb_act  [APB_COUNT];
    logic [APB_COUNT-1:0]  apb_tick;

    presc_code_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pend    (pend)
    );

    presc_stage #(
        .CODE_W    (AHB_CODE_W),
        .MAP       (MAP_AHB),
        .MAX_SHIFT (AHB_MAX_SHIFT)
    ) u_ahb_stage (
        .clk       (clk),
        .rst       (rst),
        .tick_in   (1'b1),
        .pend_code (pend.ahb),
        .tick_out  (hclk_en),
        .act_code  (ahb_code_rb)
    );

    assign apb_pend[0] = pend.apb1;
    assign apb_pend[1] = pend.apb2;

    generate
        for (genvar g = 0; g < APB_COUNT; g++) begin : g_apb
            presc_stage #(
                .CODE_W    (APB_CODE_W),
                .MAP       (MAP_APB),
                .MAX_SHIFT (APB_MAX_SHIFT)
            ) u_apb_stage (
                .clk       (clk),
                .rst       (rst),
                .tick_in   (hclk_en),
                .pend_code (apb_pend[g]),
                .tick_out  (apb_tick[g]),
                .act_code  (apb_act[g])
            );
        end
    endgenerate

    assign pclk1_en     = apb_tick[0];
    assign pclk2_en     = apb_tick[1];
    assign apb1_code_rb = apb_act[0];
    assign apb2_code_rb = apb_act[1];

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ahb_code_rb == '0 && apb1_code_rb == '0 && apb2_code_rb == '0));

    // R2
    ahb_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !ahb_code_rb[3] |-> hclk_en);

    // R5
    apb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !apb1_code_rb[2] |-> (pclk1_en == hclk_en));

    // R10
    apb_in_ahb_chk: assert property (@(posedge clk) disable iff (rst)
        (pclk1_en || pclk2_en) |-> hclk_en);

endmodule

// File: tb/bus_presc_chain_bench.sv
module bus_presc_chain_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic [3:0] wr_data = 4'h0;
    logic       hclk_en, pclk1_en, pclk2_en;
    logic [3:0] ahb_code_rb;
    logic [2:0] apb1_code_rb, apb2_code_rb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_pend [3];
    int m_act  [3];
    int m_cnt  [3];
    int cycle = 0;
    int last_h = 0;
    int gap_h = 0;
    bit saw_h = 1'b0;

    always #4 clk = ~clk;

    bus_presc_chain u_bus_presc_chain (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .hclk_en (hclk_en), .pclk1_en (pclk1_en), .pclk2_en (pclk2_en),
        .ahb_code_rb (ahb_code_rb), .apb1_code_rb (apb1_code_rb), .apb2_code_rb (apb2_code_rb)
    );

    function automatic int div_of(int idx, int code);
        if (idx == 0) begin
            if (code < 8) return 1;
            case (code)
                8: return 2;    9: return 4;    10: return 8;   11: return 16;
                12: return 64;  13: return 128; 14: return 256; default: return 512;
            endcase
        end else begin
            if (code < 4) return 1;
            case (code)
                4: return 2; 5: return 4; 6: return 8; default: return 16;
            endcase
        end
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycle);
        end
    endtask

    // One clock: compare at the falling edge, drive, advance model at rising edge
    task automatic cyc(bit en, int sel, int data);
        bit eh, e1, e2;
        string th, t1, t2;
        eh = (m_cnt[0] == div_of(0, m_act[0]) - 1);
        e1 = eh && (m_cnt[1] == div_of(1, m_act[1]) - 1);
        e2 = eh && (m_cnt[2] == div_of(2, m_act[2]) - 1);
        th = (m_act[0] < 8) ? "R2" : (m_act[0] < 12) ? "R3" : "R4";
        t1 = (m_act[1] < 4) ? "R5" : "R6";
        t2 = (m_act[2] < 4) ? "R5" : "R6";
        chk(hclk_en == eh, th, int'(hclk_en), int'(eh));
        chk(pclk1_en == e1, t1, int'(pclk1_en), int'(e1));
        chk(pclk2_en == e2, t2, int'(pclk2_en), int'(e2));
        chk(int'(ahb_code_rb) == m_act[0], "R9", int'(ahb_code_rb), m_act[0]);
        chk(int'(apb1_code_rb) == m_act[1], "R9", int'(apb1_code_rb), m_act[1]);
        chk(int'(apb2_code_rb) == m_act[2], "R9", int'(apb2_code_rb), m_act[2]);
        chk(!((pclk1_en || pclk2_en) && !hclk_en), "R10", int'(pclk1_en | pclk2_en), 0);
        saw_h = hclk_en;
        wr_en = en;
        wr_sel = 2'(sel);
        wr_data = 4'(data);
        @(posedge clk);
        if (eh) begin
            gap_h = cycle - last_h;
            last_h = cycle;
            m_cnt[0] = 0;
            m_act[0] = m_pend[0];
        end else begin
            m_cnt[0]++;
        end
        if (eh) begin
            if (e1) begin m_cnt[1] = 0; m_act[1] = m_pend[1]; end else m_cnt[1]++;
            if (e2) begin m_cnt[2] = 0; m_act[2] = m_pend[2]; end else m_cnt[2]++;
        end
        if (en) begin
            if (sel == 0) m_pend[0] = data & 15;
            else if (sel == 1) m_pend[1] = data & 7;
            else if (sel == 2) m_pend[2] = data & 7;
        end
        cycle++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
    endtask

    task automatic until_h();
        int guard;
        guard = 0;
        do begin
            cyc(1'b0, 0, 0);
            guard++;
        end while (!saw_h && guard < 2000);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin m_pend[k] = 0; m_act[k] = 0; m_cnt[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(ahb_code_rb == 4'h0 && apb1_code_rb == 3'h0 && apb2_code_rb == 3'h0, "R1",
            int'(ahb_code_rb), 0);
        chk(hclk_en && pclk1_en && pclk2_en, "R1", int'({hclk_en, pclk1_en, pclk2_en}), 7);
        run(6);

        // R2: bypass code with low bits set
        cyc(1'b1, 0, 4'b0101);
        run(10);

        // R3 / R4: every divided high-speed code
        for (int c = 8; c < 16; c++) begin
            cyc(1'b1, 0, c);
            run(2 * div_of(0, c) + 4);
        end

        // R5 / R6: first peripheral codes under a high-speed ratio of 2
        cyc(1'b1, 0, 4'b1000);
        run(40);
        for (int c = 2; c < 8; c++) begin
            cyc(1'b1, 1, c);
            run(2 * 2 * div_of(1, c) + 6);
        end

        // R7: second field written, first field must keep its code
        cyc(1'b1, 2, 3'b110);
        run(80);
        chk(apb1_code_rb == 3'b111, "R7", int'(apb1_code_rb), 7);
        chk(apb2_code_rb == 3'b110, "R7", int'(apb2_code_rb), 6);
        chk(ahb_code_rb == 4'b1000, "R7", int'(ahb_code_rb), 8);

        // R8: change ratio mid-period, old period completes
        cyc(1'b1, 0, 4'b1001);
        run(20);
        until_h();
        cyc(1'b1, 0, 4'b1000);
        chk(ahb_code_rb == 4'b1001, "R9", int'(ahb_code_rb), 9);
        until_h();
        chk(gap_h == 4, "R8", gap_h, 4);
        until_h();
        chk(gap_h == 2, "R8", gap_h, 2);

        // R11: unused select touches nothing
        cyc(1'b1, 3, 4'b1111);
        run(40);
        chk(ahb_code_rb == 4'b1000, "R11", int'(ahb_code_rb), 8);
        chk(apb1_code_rb == 3'b111, "R11", int'(apb1_code_rb), 7);
        chk(apb2_code_rb == 3'b110, "R11", int'(apb2_code_rb), 6);
        until_h();
        until_h();
        chk(gap_h == 2, "R11", gap_h, 2);

        // back to undivided everywhere
        cyc(1'b1, 1, 0);
        cyc(1'b1, 2, 3);
        cyc(1'b1, 0, 0);
        run(80);
        chk(hclk_en && pclk1_en && pclk2_en, "R5", int'({hclk_en, pclk1_en, pclk2_en}), 7);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule